// File: doc/BRIEF.md
# Masked Alarm Comparator and Event Flags

This block watches the running time of day, kept elsewhere as packed BCD seconds, minutes and hours, and raises an alarm flag when the time agrees with three programmable alarm registers. Each alarm register has its own mask bit, so any one field can be left out of the comparison. Clearing all three masks gives a daily alarm. Masking hours gives an hourly alarm. Masking everything gives a flag every second.

The same block keeps an 8-bit status register. It latches four events: alarm, watchdog expiry, supply below threshold and oscillator failure at start-up. Most of these flags clear when software reads the register. The oscillator flag is different: it survives a reset and goes away only when software writes a zero to it. The status register also holds three control bits. One of them, the calibration bit, swaps the interrupt output for a square wave derived from the system clock.

A small synchronous register port gives access to the four registers. Read data appears one cycle after the read strobe.

Top module: `rtc_alarm_flags`

## Requirements
- R1: The register addresses are: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 status. A write to an alarm register stores all 8 bits. A read of any register returns its value on `reg_rdata` in the cycle after the read strobe. Alarm registers reset to 0x80.
- R2: In each alarm register, bit 7 is the mask bit and bits 6:0 hold the BCD value. A mask of 0 puts the field into the comparison. A mask of 1 makes the comparator ignore the field.
- R3: The alarm flag (status bit 6) sets only on a cycle with `tick_sec` high in which every unmasked field equals the matching time input. Equal time inputs with no tick leave it clear.
- R4: The status layout is: bit 7 watchdog, bit 6 alarm, bit 5 supply-low, bit 4 oscillator-fail, bit 3 always reads 0, bit 2 calibration, bit 1 write-hold, bit 0 read-hold.
- R5: A cycle with `wdog_zero` high sets bit 7. A cycle with `pwr_low` high sets bit 5.
- R6: A status read returns the flags as they were before the read, then clears bits 7, 6 and 5. An event in the same cycle as the read still leaves its flag set afterwards.
- R7: Writes to status bits 7, 6 and 5 have no effect.
- R8: `osc_dead` sets bit 4. Only a status write with bit 4 equal to 0 clears it. Writing 1 to bit 4 does not set it. Reads and `rst` leave it unchanged.
- R9: Status bits 2, 1 and 0 take the written value on a status write and read back unchanged.
- R10: With the calibration bit at 0, `int_out` is high one cycle after any of bits 7, 6 or 5 is set. With the calibration bit at 1, `int_out` is a square wave that toggles every CLK_HZ/(2*CAL_HZ) cycles.
- R11: `rst` clears bits 7, 6, 5, 2, 1 and 0 of the status register. It also clears `reg_rdata` and `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tick_sec | input | 1 | One-cycle pulse per second, time inputs valid |
| time_sec | input | 8 | Current seconds, BCD |
| time_min | input | 8 | Current minutes, BCD |
| time_hr | input | 8 | Current hours, BCD |
| wdog_zero | input | 1 | Watchdog count reached zero |
| pwr_low | input | 1 | Supply below threshold |
| osc_dead | input | 1 | Oscillator not running after start-up |
| int_out | output | 1 | Interrupt or calibration square wave |

## Verification
The assertions take for granted that the time inputs are stable and valid whenever `tick_sec` is high. They also assume that a read and a write never target the status register in the same cycle. The bench meets both conditions: it drives every input at the falling edge, sets the time in the same cycle as the one-cycle tick, and issues one register access at a time. Event pulses are one cycle wide. The one exception is a deliberate pulse that coincides with a status read.

// File: rtl/rtc_af_pkg.sv
package rtc_af_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_FIELDS = 3;

  typedef enum logic [1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HR   = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int BIT_WDF  = 7;
  localparam int BIT_ALM  = 6;
  localparam int BIT_PWR  = 5;
  localparam int BIT_OSC  = 4;
  localparam int BIT_ZERO = 3;
  localparam int BIT_CAL  = 2;
  localparam int BIT_WH   = 1;
  localparam int BIT_RH   = 0;

  localparam logic [REG_W-1:0] ALARM_RST = 8'h80;
endpackage

// File: rtl/af_alarm_cmp.sv
module af_alarm_cmp
  import rtc_af_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int NF = NUM_FIELDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NF-1:0]    wr_sel,
  input  logic [DW-1:0]    wdata,
  input  logic [NF*DW-1:0] time_vec,
  output logic [NF*DW-1:0] alarm_vec,
  output logic             match
);
  localparam int VW = DW - 1;

  logic [NF-1:0] field_hit;

  for (genvar g = 0; g < NF; g++) begin : g_field
    logic [DW-1:0] alarm_q;
    logic [VW-1:0] now_val;

    always_ff @(posedge clk) begin
      if (rst) begin
        alarm_q <= ALARM_RST[DW-1:0];
      end else if (wr_en && wr_sel[g]) begin
        alarm_q <= wdata;
      end
    end

    assign now_val      = time_vec[g*DW +: VW];
    assign field_hit[g] = alarm_q[DW-1] | (alarm_q[VW-1:0] == now_val);
    assign alarm_vec[g*DW +: DW] = alarm_q;
  end

  assign match = &field_hit;
endmodule

// File: rtl/af_flag_reg.sv
module af_flag_reg
  import rtc_af_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             alarm_evt,
  input  logic             wdog_evt,
  input  logic             pwr_evt,
  input  logic             osc_evt,
  output logic [REG_W-1:0] flags
);
  logic wdf_q, alm_q, pwr_q;
  logic cal_q, wh_q, rh_q;
  logic osc_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wdf_q <= 1'b0;
      alm_q <= 1'b0;
      pwr_q <= 1'b0;
    end else begin
      wdf_q <= wdog_evt  | (wdf_q & ~rd_en);
      alm_q <= alarm_evt | (alm_q & ~rd_en);
      pwr_q <= pwr_evt   | (pwr_q & ~rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q <= 1'b0;
      wh_q  <= 1'b0;
      rh_q  <= 1'b0;
    end else if (wr_en) begin
      cal_q <= wdata[BIT_CAL];
      wh_q  <= wdata[BIT_WH];
      rh_q  <= wdata[BIT_RH];
    end
  end

  always_ff @(posedge clk) begin
    if (osc_evt) begin
      osc_q <= 1'b1;
    end else if (wr_en && !wdata[BIT_OSC]) begin
      osc_q <= 1'b0;
    end
  end

  always_comb begin
    flags           = '0;
    flags[BIT_WDF]  = wdf_q;
    flags[BIT_ALM]  = alm_q;
    flags[BIT_PWR]  = pwr_q;
    flags[BIT_OSC]  = osc_q;
    flags[BIT_ZERO] = 1'b0;
    flags[BIT_CAL]  = cal_q;
    flags[BIT_WH]   = wh_q;
    flags[BIT_RH]   = rh_q;
  end
endmodule

// File: rtl/af_cal_gen.sv
module af_cal_gen #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst,
  output logic sq
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sq    <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      sq    <= ~sq;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_af_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int CAL_HZ = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_sec,
  input  logic [7:0] time_sec,
  input  logic [7:0] time_min,
  input  logic [7:0] time_hr,
  input  logic       wdog_zero,
  input  logic       pwr_low,
  input  logic       osc_dead,
  output logic       int_out
);
  localparam int HALF = (CLK_HZ / (2 * CAL_HZ)) < 1 ? 1 : CLK_HZ / (2 * CAL_HZ);

  logic [NUM_FIELDS-1:0]       alarm_sel;
  logic [NUM_FIELDS*REG_W-1:0] time_vec;
  logic [NUM_FIELDS*REG_W-1:0] alarm_vec;
  logic                        alarm_match;
  logic                        stat_wr, stat_rd;
  logic [REG_W-1:0]            flags_q;
  logic                        cal_sq;
  logic                        irq_any;

  assign alarm_sel = {reg_addr == SEL_HR, reg_addr == SEL_MIN, reg_addr == SEL_SEC};
  assign time_vec  = {time_hr, time_min, time_sec};
  assign stat_wr   = reg_wr && (reg_addr == SEL_STAT);
  assign stat_rd   = reg_rd && (reg_addr == SEL_STAT);

  af_alarm_cmp #(.DW(REG_W), .NF(NUM_FIELDS)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_sel    (alarm_sel),
    .wdata     (reg_wdata),
    .time_vec  (time_vec),
    .alarm_vec (alarm_vec),
    .match     (alarm_match)
  );

  af_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (stat_wr),
    .rd_en     (stat_rd),
    .wdata     (reg_wdata),
    .alarm_evt (tick_sec & alarm_match),
    .wdog_evt  (wdog_zero),
    .pwr_evt   (pwr_low),
    .osc_evt   (osc_dead),
    .flags     (flags_q)
  );

  af_cal_gen #(.HALF(HALF)) u_cal (
    .clk (clk),
    .rst (rst),
    .sq  (cal_sq)
  );

  assign irq_any = flags_q[BIT_WDF] | flags_q[BIT_ALM] | flags_q[BIT_PWR];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        SEL_SEC: reg_rdata <= alarm_vec[0*REG_W +: REG_W];
        SEL_MIN: reg_rdata <= alarm_vec[1*REG_W +: REG_W];
        SEL_HR:  reg_rdata <= alarm_vec[2*REG_W +: REG_W];
        default: reg_rdata <= flags_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out <= 1'b0;
    end else begin
      int_out <= flags_q[BIT_CAL] ? cal_sq : irq_any;
    end
  end
endmodule

// File: rtl/af_flags_chk.sv
module af_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tick_sec,
  input logic       wdog_zero,
  input logic       pwr_low,
  input logic [7:0] flags_q,
  input logic       int_out
);
  assert_alarm_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[6]) |-> $past(tick_sec));

  assert_wdog_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wdog_zero)) |-> flags_q[7]);

  assert_pwr_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pwr_low)) |-> flags_q[5]);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_rd && reg_addr == 2'd3) && !$past(wdog_zero)) |-> !flags_q[7]);

  assert_osc_clear_by_write_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q[4]) |-> $past(reg_wr && reg_addr == 2'd3 && !reg_wdata[4]));

  assert_zero_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_rd && reg_addr == 2'd3)) |-> (reg_rdata[3] == 1'b0));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flags_q[2])) |-> (int_out == $past(flags_q[7] | flags_q[6] | flags_q[5])));
endmodule

bind rtc_alarm_flags af_flags_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tick_sec  (tick_sec),
  .wdog_zero (wdog_zero),
  .pwr_low   (pwr_low),
  .flags_q   (flags_q),
  .int_out   (int_out)
);

// File: tb/rtc_alarm_flags_bench.sv
module rtc_alarm_flags_bench;
  localparam int CLK_HZ = 8192;
  localparam int CAL_HZ = 512;
  localparam int HALF   = CLK_HZ / (2 * CAL_HZ);
  localparam int NVEC   = 8;

  // {alarm sec, alarm min, alarm hr, time sec, time min, time hr, expected alarm flag}
  localparam logic [48:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
    {8'h30, 8'h45, 8'h12, 8'h30, 8'h45, 8'h12, 1'b1},
    {8'h30, 8'h45, 8'h12, 8'h31, 8'h45, 8'h12, 1'b0},
    {8'hB0, 8'h45, 8'h12, 8'h59, 8'h45, 8'h12, 1'b1},
    {8'h80, 8'h80, 8'h80, 8'h17, 8'h33, 8'h09, 1'b1},
    {8'h30, 8'h45, 8'h12, 8'h30, 8'h45, 8'h13, 1'b0},
    {8'h30, 8'h45, 8'h92, 8'h30, 8'h45, 8'h23, 1'b1},
    {8'hB0, 8'h10, 8'h80, 8'h00, 8'h11, 8'h05, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_sec = 1'b0;
  logic [7:0] time_sec = '0, time_min = '0, time_hr = '0;
  logic       wdog_zero = 1'b0, pwr_low = 1'b0, osc_dead = 1'b0;
  logic       int_out;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_flags #(.CLK_HZ(CLK_HZ), .CAL_HZ(CAL_HZ)) u_rtc_alarm_flags (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_sec(tick_sec),
    .time_sec(time_sec), .time_min(time_min), .time_hr(time_hr),
    .wdog_zero(wdog_zero), .pwr_low(pwr_low), .osc_dead(osc_dead), .int_out(int_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int toggles;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 rdata after reset", reg_rdata, 8'h00);
    check("R11 int_out after reset", {7'd0, int_out}, 8'h00);
    rd(2'd0, d); check("R1 alarm sec reset", d, 8'h80);
    rd(2'd2, d); check("R1 alarm hr reset", d, 8'h80);
    rd(2'd3, d); check("R4 status reset", d, 8'h00);

    // Vector walk: R2 masks, R3 tick-gated match
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, VEC[i][48:41]);
      wr(2'd1, VEC[i][40:33]);
      wr(2'd2, VEC[i][32:25]);
      rd(2'd3, d);
      @(negedge clk);
      tick_sec = 1'b1; time_sec = VEC[i][24:17]; time_min = VEC[i][16:9]; time_hr = VEC[i][8:1];
      @(negedge clk); tick_sec = 1'b0;
      rd(2'd3, d);
      check($sformatf("R2 R3 vector %0d alarm flag", i), {7'd0, d[6]}, {7'd0, VEC[i][0]});
    end
    rd(2'd1, d); check("R1 alarm min readback", d, 8'h10);

    // R3 time equal but no tick
    wr(2'd0, 8'h05); wr(2'd1, 8'h06); wr(2'd2, 8'h07);
    time_sec = 8'h05; time_min = 8'h06; time_hr = 8'h07;
    repeat (4) @(negedge clk);
    rd(2'd3, d); check("R3 no tick no alarm", {7'd0, d[6]}, 8'h00);

    // R5, R6 watchdog flag set then cleared by read
    @(negedge clk); wdog_zero = 1'b1; @(negedge clk); wdog_zero = 1'b0;
    rd(2'd3, d); check("R5 watchdog flag set", {7'd0, d[7]}, 8'h01);
    rd(2'd3, d); check("R6 watchdog flag cleared by read", {7'd0, d[7]}, 8'h00);

    // R6 event coinciding with read survives
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3; wdog_zero = 1'b1;
    @(negedge clk); reg_rd = 1'b0; wdog_zero = 1'b0; d = reg_rdata;
    check("R6 coincident read shows old value", {7'd0, d[7]}, 8'h00);
    rd(2'd3, d); check("R6 coincident event kept", {7'd0, d[7]}, 8'h01);

    // R7 read-only bits ignore writes
    wr(2'd3, 8'hE0);
    rd(2'd3, d); check("R7 write to event bits ignored", d, 8'h00);

    // R9, R4 control bits and zero bit (calibration kept 0 here)
    wr(2'd3, 8'h0B);
    rd(2'd3, d); check("R9 R4 control readback", d, 8'h03);
    wr(2'd3, 8'h00);

    // R10 interrupt follows supply-low flag
    @(negedge clk); pwr_low = 1'b1; @(negedge clk); pwr_low = 1'b0;
    @(negedge clk);
    check("R10 int_out high after pwr flag", {7'd0, int_out}, 8'h01);
    rd(2'd3, d); check("R5 pwr flag set", {7'd0, d[5]}, 8'h01);
    @(negedge clk);
    check("R10 int_out low after clear", {7'd0, int_out}, 8'h00);

    // R8 oscillator flag
    wr(2'd3, 8'h10);
    rd(2'd3, d); check("R8 write 1 does not set osc", {7'd0, d[4]}, 8'h00);
    @(negedge clk); osc_dead = 1'b1; @(negedge clk); osc_dead = 1'b0;
    rd(2'd3, d); check("R8 osc flag set", {7'd0, d[4]}, 8'h01);
    rd(2'd3, d); check("R8 osc flag kept after read", {7'd0, d[4]}, 8'h01);
    wr(2'd3, 8'h17);
    do_reset();
    rd(2'd3, d); check("R8 R11 osc kept, control cleared by reset", d, 8'h10);
    wr(2'd3, 8'h00);
    rd(2'd3, d); check("R8 osc cleared by write 0", {7'd0, d[4]}, 8'h00);

    // R10 calibration square wave
    wr(2'd3, 8'h04);
    repeat (2) @(negedge clk);
    prev = int_out; toggles = 0;
    for (int c = 0; c < 16 * HALF; c++) begin
      @(negedge clk);
      if (int_out != prev) toggles++;
      prev = int_out;
    end
    check("R10 calibration toggle count", 8'(toggles), 8'd16);
    wr(2'd3, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule